// File: doc/BRIEF.md
# Big-Endian Masked Data Memory Port

This block is the data side of a small processor's memory system. It holds a byte-addressed RAM of 2^P bytes and serves byte, halfword and word loads and stores from a one-cycle request interface. Multi-byte values are stored with the most significant byte at the lowest address. Reads can return signed or unsigned values.

Addresses never fault. Upper address bits beyond the RAM size are dropped. A halfword address has its lowest bit forced to zero, and a word address has its two lowest bits forced to zero. This gives wrap-around and silent alignment.

A second, byte-wide port lets a loader or debugger fill and inspect the RAM one byte at a time. It uses the same address wrapping. When both ports present a request in the same cycle, the byte port takes the cycle.

Top module: `mbp_port`

## Requirements
- R1: After reset, `rd_valid` and `dbg_rvalid` are low and every RAM byte reads as zero.
- R2: A word access (size code 2) ignores address bits 1:0. On a read, bits 31:24 of the data come from the lowest byte address and bits 7:0 from the highest.
- R3: A halfword access (size code 1) ignores address bit 0. The byte at the even address carries bits 15:8 and the next byte carries bits 7:0.
- R4: A byte access (size code 0) reads or writes exactly the addressed byte, using data bits 7:0.
- R5: Every address is reduced modulo 2^P, so address bits P and above have no effect.
- R6: A halfword read with `req_signed` high copies bit 15 into bits 31:16. With `req_signed` low, bits 31:16 are zero.
- R7: A byte read with `req_signed` high copies bit 7 into bits 31:8. With `req_signed` low, bits 31:8 are zero.
- R8: Read data and `rd_valid` appear one clock after a core read request. Core writes and idle cycles leave `rd_valid` low in the next cycle.
- R9: A write changes only the bytes covered by its size. Other bytes in the same word keep their contents.
- R10: The byte port writes `dbg_wdata` to, or returns in `dbg_rdata` one clock later, the single byte at `dbg_addr` reduced modulo 2^P, with `dbg_rvalid` high.
- R11: In a cycle where `dbg_valid` is high, a core request is dropped: it writes nothing and raises no `rd_valid`.
- R12: Size code 3 behaves exactly like a word access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears state and RAM |
| req_valid | input | 1 | Core request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_signed | input | 1 | Sign-extend load data |
| req_addr | input | 32 | Core byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| rd_valid | output | 1 | Load data valid |
| rd_data | output | 32 | Extended load data |
| dbg_valid | input | 1 | Byte-port request present |
| dbg_write | input | 1 | 1 = write byte, 0 = read byte |
| dbg_addr | input | 32 | Byte-port address |
| dbg_wdata | input | 8 | Byte to write |
| dbg_rvalid | output | 1 | Byte-port read data valid |
| dbg_rdata | output | 8 | Byte read through the byte port |

## Verification
Lane steering errors show up on the next matching load. A swapped or missing lane enable leaves a wrong byte in a specific position of `rd_data` one cycle after a word read of that location. A mask that keeps too many or too few address bits makes a wrapped address or an unaligned halfword or word read return another location's bytes. Extension errors appear in bits 31:8 or 31:16 in the same cycle as `rd_valid`. A lost reset clear shows as nonzero data on the first read of an unwritten word.

// File: rtl/mbp_pkg.sv
package mbp_pkg;

    localparam int LANES = 4;
    localparam int BYTE_W = 8;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef logic [LANES-1:0][BYTE_W-1:0] lane_bytes_t;

    typedef struct packed {
        logic       rd_v;
        logic       dbg_v;
        logic [1:0] size;
        logic [1:0] off;
        logic       sgn;
    } ctrl_t;

endpackage

// File: rtl/mbp_addr_mask.sv
module mbp_addr_mask #(
    parameter int P = 10
) (
    input  logic [31:0]  addr,
    input  logic [1:0]   size,
    output logic [P-3:0] row,
    output logic [1:0]   off
);
    import mbp_pkg::*;

    localparam logic [P-1:0] SPAN_MASK = {P{1'b1}};

    logic [P-1:0] wrapped;
    logic [P-1:0] aligned;

    always_comb begin
        wrapped = addr[P-1:0] & SPAN_MASK;
        aligned = wrapped;
        if (size == SZ_HALF) begin
            aligned[0] = 1'b0;
        end else if (size != SZ_BYTE) begin
            aligned[1:0] = 2'b00;
        end
        row = aligned[P-1:2];
        off = aligned[1:0];
    end

endmodule

// File: rtl/mbp_lane_steer.sv
module mbp_lane_steer (
    input  logic                 wr_en,
    input  logic                 from_dbg,
    input  logic [1:0]           size,
    input  logic [1:0]           off,
    input  logic [31:0]          core_wdata,
    input  logic [7:0]           dbg_wdata,
    output logic [3:0]           lane_we,
    output mbp_pkg::lane_bytes_t lane_wd
);
    import mbp_pkg::*;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            lane_we[g] = 1'b0;
            lane_wd[g] = core_wdata[7:0];
            if (from_dbg) begin
                lane_we[g] = wr_en && (off == g[1:0]);
                lane_wd[g] = dbg_wdata;
            end else if (size == SZ_BYTE) begin
                lane_we[g] = wr_en && (off == g[1:0]);
                lane_wd[g] = core_wdata[7:0];
            end else if (size == SZ_HALF) begin
                lane_we[g] = wr_en && (off[1] == g[1]);
                lane_wd[g] = g[0] ? core_wdata[7:0] : core_wdata[15:8];
            end else begin
                lane_we[g] = wr_en;
                lane_wd[g] = core_wdata[31-8*g -: 8];
            end
        end
    end

    // R9: a store touches one, two or four lanes, never three
    always_comb begin
        if (wr_en) begin
            a_r9_lane_count: assert ($countones(lane_we) == 1 ||
                                     $countones(lane_we) == 2 ||
                                     $countones(lane_we) == 4)
                else $error("R9 lane enable count %0d", $countones(lane_we));
        end
    end

endmodule

// File: rtl/mbp_lane_bank.sv
module mbp_lane_bank #(
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [ROW_W-1:0] row,
    input  logic [7:0]       wd,
    output logic [7:0]       rd
);
    localparam int DEPTH = 1 << ROW_W;

    logic [7:0] mem_q [DEPTH];
    logic [7:0] rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
            rd_q <= '0;
        end else begin
            rd_q <= mem_q[row];
            if (we) begin
                mem_q[row] <= wd;
            end
        end
    end

    assign rd = rd_q;

endmodule

// File: rtl/mbp_read_align.sv
module mbp_read_align (
    input  mbp_pkg::lane_bytes_t lanes,
    input  logic [1:0]           size,
    input  logic [1:0]           off,
    input  logic                 sgn,
    output logic [31:0]          data,
    output logic [7:0]           single
);
    import mbp_pkg::*;

    logic [15:0] half;

    always_comb begin
        single = lanes[off];
        half   = off[1] ? {lanes[2], lanes[3]} : {lanes[0], lanes[1]};
        if (size == SZ_BYTE) begin
            data = {{24{sgn & single[7]}}, single};
        end else if (size == SZ_HALF) begin
            data = {{16{sgn & half[15]}}, half};
        end else begin
            data = {lanes[0], lanes[1], lanes[2], lanes[3]};
        end
    end

endmodule

// File: rtl/mbp_port.sv
module mbp_port #(
    parameter int P = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  req_size,
    input  logic        req_signed,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        rd_valid,
    output logic [31:0] rd_data,
    input  logic        dbg_valid,
    input  logic        dbg_write,
    input  logic [31:0] dbg_addr,
    input  logic [7:0]  dbg_wdata,
    output logic        dbg_rvalid,
    output logic [7:0]  dbg_rdata
);
    import mbp_pkg::*;

    localparam int ROW_W = P - 2;

    ctrl_t ctrl_d, ctrl_q;

    logic [31:0]      sel_addr;
    logic [1:0]       sel_size;
    logic             wr_en;
    logic [ROW_W-1:0] row;
    logic [1:0]       off;
    logic [3:0]       lane_we;
    lane_bytes_t      lane_wd;
    lane_bytes_t      lane_rd;

    always_comb begin
        ctrl_d       = ctrl_q;
        sel_addr     = req_addr;
        sel_size     = req_size;
        wr_en        = req_valid && req_write;
        ctrl_d.rd_v  = req_valid && !req_write && !dbg_valid;
        ctrl_d.dbg_v = dbg_valid && !dbg_write;
        ctrl_d.sgn   = req_signed;
        if (dbg_valid) begin
            sel_addr = dbg_addr;
            sel_size = SZ_BYTE;
            wr_en    = dbg_write;
        end
        ctrl_d.size = sel_size;
        ctrl_d.off  = off;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    mbp_addr_mask #(.P(P)) u_mask (
        .addr (sel_addr),
        .size (sel_size),
        .row  (row),
        .off  (off)
    );

    mbp_lane_steer u_steer (
        .wr_en      (wr_en),
        .from_dbg   (dbg_valid),
        .size       (sel_size),
        .off        (off),
        .core_wdata (req_wdata),
        .dbg_wdata  (dbg_wdata),
        .lane_we    (lane_we),
        .lane_wd    (lane_wd)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        mbp_lane_bank #(.ROW_W(ROW_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (lane_we[g]),
            .row   (row),
            .wd    (lane_wd[g]),
            .rd    (lane_rd[g])
        );
    end

    mbp_read_align u_align (
        .lanes  (lane_rd),
        .size   (ctrl_q.size),
        .off    (ctrl_q.off),
        .sgn    (ctrl_q.sgn),
        .data   (rd_data),
        .single (dbg_rdata)
    );

    assign rd_valid   = ctrl_q.rd_v;
    assign dbg_rvalid = ctrl_q.dbg_v;

    a_r8_valid_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write && !dbg_valid))
        else $error("R8 rd_valid without a prior read");

    a_r8_read_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !dbg_valid) |=> rd_valid)
        else $error("R8 read not answered next cycle");

    a_r11_dbg_blocks_core: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_valid |=> !rd_valid)
        else $error("R11 core read served during byte-port cycle");

    a_r10_dbg_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_valid && !dbg_write) |=> dbg_rvalid)
        else $error("R10 byte-port read not answered");

    a_r7_byte_signext: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && ctrl_q.size == SZ_BYTE) |->
            (rd_data[31:8] == (ctrl_q.sgn ? {24{rd_data[7]}} : 24'd0)))
        else $error("R7 byte extension wrong");

    a_r6_half_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && ctrl_q.size == SZ_HALF) |->
            (rd_data[31:16] == (ctrl_q.sgn ? {16{rd_data[15]}} : 16'd0)))
        else $error("R6 halfword extension wrong");

endmodule

// File: tb/mbp_port_test.sv
module mbp_port_test;

    localparam int CLK_PERIOD = 10;
    localparam int P = 10;
    localparam int NV = 20;

    // {write, size[1:0], signed, addr[31:0], wdata[31:0], expect[31:0], req[3:0]}
    localparam logic [103:0] VEC [NV] = '{
        {1'b1, 2'd2, 1'b0, 32'h0000_0100, 32'h1122_3344, 32'h0,          4'd2},  // R2 store
        {1'b0, 2'd2, 1'b0, 32'h0000_0100, 32'h0,         32'h1122_3344, 4'd2},  // R2
        {1'b0, 2'd2, 1'b0, 32'h0000_0103, 32'h0,         32'h1122_3344, 4'd2},  // R2 low bits ignored
        {1'b0, 2'd1, 1'b0, 32'h0000_0100, 32'h0,         32'h0000_1122, 4'd3},  // R3
        {1'b0, 2'd1, 1'b0, 32'h0000_0103, 32'h0,         32'h0000_3344, 4'd3},  // R3 bit 0 ignored
        {1'b0, 2'd0, 1'b0, 32'h0000_0101, 32'h0,         32'h0000_0022, 4'd4},  // R4
        {1'b0, 2'd0, 1'b0, 32'h0000_0103, 32'h0,         32'h0000_0044, 4'd4},  // R4
        {1'b0, 2'd2, 1'b0, 32'h1234_5500, 32'h0,         32'h1122_3344, 4'd5},  // R5 wrap
        {1'b1, 2'd1, 1'b0, 32'h0000_0205, 32'hFFFF_8081, 32'h0,          4'd3},  // R3 store
        {1'b0, 2'd2, 1'b0, 32'h0000_0204, 32'h0,         32'h8081_0000, 4'd9},  // R9
        {1'b0, 2'd1, 1'b1, 32'h0000_0204, 32'h0,         32'hFFFF_8081, 4'd6},  // R6 signed
        {1'b0, 2'd1, 1'b0, 32'h0000_0204, 32'h0,         32'h0000_8081, 4'd6},  // R6 unsigned
        {1'b1, 2'd0, 1'b0, 32'h0000_0207, 32'hABCD_EFF0, 32'h0,          4'd4},  // R4 store
        {1'b0, 2'd0, 1'b1, 32'h0000_0207, 32'h0,         32'hFFFF_FFF0, 4'd7},  // R7 signed
        {1'b0, 2'd0, 1'b0, 32'h0000_0207, 32'h0,         32'h0000_00F0, 4'd7},  // R7 unsigned
        {1'b0, 2'd2, 1'b0, 32'h0000_0204, 32'h0,         32'h8081_00F0, 4'd9},  // R9
        {1'b1, 2'd0, 1'b0, 32'h0000_0206, 32'h0000_007F, 32'h0,          4'd9},  // R9 store
        {1'b0, 2'd0, 1'b1, 32'h0000_0206, 32'h0,         32'h0000_007F, 4'd7},  // R7 positive
        {1'b0, 2'd3, 1'b0, 32'h0000_0205, 32'h0,         32'h8081_7FF0, 4'd12}, // R12
        {1'b1, 2'd3, 1'b0, 32'h0000_0301, 32'hCAFE_BABE, 32'h0,          4'd12}  // R12 store
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_signed = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        dbg_valid = 1'b0;
    logic        dbg_write = 1'b0;
    logic [31:0] dbg_addr = '0;
    logic [7:0]  dbg_wdata = '0;
    logic        dbg_rvalid;
    logic [7:0]  dbg_rdata;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbp_port #(.P(P)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_size   (req_size),
        .req_signed (req_signed),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .dbg_valid  (dbg_valid),
        .dbg_write  (dbg_write),
        .dbg_addr   (dbg_addr),
        .dbg_wdata  (dbg_wdata),
        .dbg_rvalid (dbg_rvalid),
        .dbg_rdata  (dbg_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one core request at a falling edge, sample at the next falling edge
    task automatic core_op(input logic w, input logic [1:0] sz, input logic sg,
                           input logic [31:0] a, input logic [31:0] wd);
        req_valid  = 1'b1;
        req_write  = w;
        req_size   = sz;
        req_signed = sg;
        req_addr   = a;
        req_wdata  = wd;
        @(negedge clk);
        req_valid  = 1'b0;
        req_write  = 1'b0;
    endtask

    task automatic dbg_op(input logic w, input logic [31:0] a, input logic [7:0] wd);
        dbg_valid = 1'b1;
        dbg_write = w;
        dbg_addr  = a;
        dbg_wdata = wd;
        @(negedge clk);
        dbg_valid = 1'b0;
        dbg_write = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
        check("R1 dbg_rvalid", {31'd0, dbg_rvalid}, 32'd0);
        core_op(1'b0, 2'd2, 1'b0, 32'h0000_0000, 32'h0);
        check("R1 word 0x000", rd_data, 32'h0);
        core_op(1'b0, 2'd2, 1'b0, 32'h0000_03FC, 32'h0);
        check("R1 word 0x3FC", rd_data, 32'h0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [103:0] v;
            v = VEC[i];
            core_op(v[103], v[102:101], v[100], v[99:68], v[67:36]);
            if (!v[103]) begin
                checks++;
                if (!rd_valid || rd_data !== v[35:4]) begin
                    fails++;
                    $display("FAIL R%0d vector %0d actual=%h valid=%0b expected=%h",
                             v[3:0], i, rd_data, rd_valid, v[35:4]);
                end
            end
        end

        // R12 word store through size code 3 ignored low bits
        core_op(1'b0, 2'd2, 1'b0, 32'h0000_0300, 32'h0);
        check("R12 size3 store", rd_data, 32'hCAFE_BABE);

        // R8 latency and valid behaviour
        core_op(1'b1, 2'd2, 1'b0, 32'h0000_0010, 32'h0102_0304);
        check("R8 no valid after write", {31'd0, rd_valid}, 32'd0);
        core_op(1'b0, 2'd2, 1'b0, 32'h0000_0010, 32'h0);
        check("R8 valid after read", {31'd0, rd_valid}, 32'd1);
        check("R8 data after read", rd_data, 32'h0102_0304);
        @(negedge clk);
        check("R8 valid drops when idle", {31'd0, rd_valid}, 32'd0);

        // R10 byte port, with wrap
        dbg_op(1'b1, 32'h0000_07FF, 8'h5A);
        check("R10 no dbg_rvalid on write", {31'd0, dbg_rvalid}, 32'd0);
        dbg_op(1'b0, 32'h0000_03FF, 8'h00);
        check("R10 dbg_rvalid", {31'd0, dbg_rvalid}, 32'd1);
        check("R10 dbg read wrapped", {24'd0, dbg_rdata}, 32'h5A);
        core_op(1'b0, 2'd2, 1'b0, 32'h0000_03FC, 32'h0);
        check("R10 core sees dbg byte", rd_data, 32'h0000_005A);
        dbg_op(1'b0, 32'hFFFF_FD01, 8'h00);
        check("R10 dbg read of core data", {24'd0, dbg_rdata}, 32'h22);

        // R11 byte port takes the cycle
        dbg_valid = 1'b1;
        dbg_write = 1'b0;
        dbg_addr  = 32'h0000_0100;
        core_op(1'b1, 2'd2, 1'b0, 32'h0000_0100, 32'hDEAD_BEEF);
        dbg_valid = 1'b0;
        check("R11 dbg read served", {24'd0, dbg_rdata}, 32'h11);
        core_op(1'b0, 2'd2, 1'b0, 32'h0000_0100, 32'h0);
        check("R11 core store dropped", rd_data, 32'h1122_3344);
        dbg_valid = 1'b1;
        dbg_addr  = 32'h0000_0101;
        core_op(1'b0, 2'd2, 1'b0, 32'h0000_0100, 32'h0);
        dbg_valid = 1'b0;
        check("R11 core read dropped", {31'd0, rd_valid}, 32'd0);

        // R5 store through a wrapped address
        core_op(1'b1, 2'd0, 1'b0, 32'hFFFF_F020, 32'h0000_00C3);
        core_op(1'b0, 2'd0, 1'b0, 32'h0000_0020, 32'h0);
        check("R5 wrapped store", rd_data, 32'h0000_00C3);

        finish_run();
    end

endmodule